// File: doc/BRIEF.md
# Trap and Interrupt-Return Context Sequencer

This block owns the core context of a small 8-bit CPU: the 16-bit program counter, the accumulator, the X index register, the condition flags with a two-bit interrupt mask, and the 16-bit stack pointer. It runs the multi-cycle memory sequences that save this context to a descending byte stack on a software trap and restore it on a return from interrupt. It reaches memory through one synchronous byte port, and every access takes one clock cycle. After reset it fetches the program counter from the reset vector.

Single-cycle commands reset the stack pointer and set or open the interrupt mask. Two further commands, halt and wait, open the mask and put the block into a low-power state. It stays there until a wake input arrives. A context-load input lets the surrounding core place register values in the block while it is idle.

Top module: `trap_ctx_sequencer`

## Requirements
- R1: After reset the block reads address 0xFFFE (high byte) and then 0xFFFF (low byte) into the program counter. It sets the stack pointer to 0x01FF, the mask to {I1,I0}=11, and A, X and all flags to 0. It then pulses done.
- R2: A trap (cmdOp 0) writes five bytes at the current stack pointer, going downward in this order: PC low, PC high, X, A, packed condition byte.
- R3: Each stack write decrements the stack pointer by one. A trap makes exactly five writes and leaves the stack pointer five below its start.
- R4: The packed condition byte is {1,1,I1,H,I0,N,Z,C} from bit 7 down to bit 0. ccOut always shows this packing.
- R5: After stacking, a trap sets {I1,I0}=11. It then loads the PC big-endian from 0xFFFC (high byte) and 0xFFFD (low byte). A and X are left unchanged.
- R6: An interrupt return (cmdOp 1) reads from SP+1 to SP+5, incrementing the stack pointer before each read. The bytes go to the condition byte, A, X, PC high and PC low in that order.
- R7: The popped condition byte restores C, Z, N, H, I0 and I1 from the bit positions of R4. Bits 7 and 6 are ignored.
- R8: The stack-reset command (cmdOp 2) sets the stack pointer to 0x01FF.
- R9: Mask-set (cmdOp 3) makes {I1,I0}=11. Mask-reset (cmdOp 4) makes {I1,I0}=10.
- R10: Halt (cmdOp 5) and wait (cmdOp 6) set {I1,I0}=10 and raise sleeping and busy. The block stays asleep until wakeIn is high for a cycle.
- R11: While busy or asleep, commands and context loads are ignored. When idle, cmdOp 7 has no effect. A context load in the same cycle as a command is also ignored.
- R12: done is a one-cycle pulse. Counting from the clock edge that accepts the request, done rises after 9 cycles for a trap and after 7 cycles for an interrupt return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request strobe |
| cmdOp | input | 3 | Command code (see requirements) |
| ctxLoad | input | 1 | Load the context inputs when idle |
| pcIn | input | 16 | Program counter value to load |
| accIn | input | 8 | Accumulator value to load |
| xIn | input | 8 | X register value to load |
| flagsIn | input | 4 | Flags to load, {H,N,Z,C} |
| spIn | input | 16 | Stack pointer value to load |
| wakeIn | input | 1 | Ends the low-power state |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Read data, valid the cycle after the address |
| pcOut | output | 16 | Program counter |
| accOut | output | 8 | Accumulator |
| xOut | output | 8 | X register |
| ccOut | output | 8 | Packed condition byte |
| spOut | output | 16 | Stack pointer |
| busy | output | 1 | Sequence running or asleep |
| done | output | 1 | End-of-sequence pulse |
| sleeping | output | 1 | Low-power state |

## Verification
The bench builds the block with its default parameters: a stack top of 0x01FF, the trap vector at 0xFFFC and the reset vector at 0xFFFE. Its memory model covers the 512-byte stack page and the four vector bytes. Random stack pointers across that page, random register contents and random mask states exercise each push and pop position. Pairing a trap with an immediate return checks that every field round-trips, including both mask bits.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_TRAP = 3'd0, OP_IRET = 3'd1, OP_STACK_RST = 3'd2, OP_MASK_SET = 3'd3,
    OP_MASK_CLR = 3'd4, OP_HALT = 3'd5, OP_WAIT = 3'd6, OP_NONE = 3'd7
  } cmdOp_e;

  typedef enum logic [1:0] {ADDR_SP, ADDR_SP_NEXT, ADDR_VEC_HI, ADDR_VEC_LO} addrSel_e;

  // order equals the push step number
  typedef enum logic [2:0] {BYTE_PCL, BYTE_PCH, BYTE_X, BYTE_A, BYTE_CC} byteSel_e;

  typedef enum logic [2:0] {CAP_NONE, CAP_PCH, CAP_PCL, CAP_CC, CAP_A, CAP_X} capSel_e;

  typedef struct packed {
    logic     memWe;
    addrSel_e addrSel;
    logic     vecTrap;
    byteSel_e wrSel;
    capSel_e  capSel;
    logic     spDec;
    logic     spInc;
    logic     spReset;
    logic     maskFull;
    logic     maskOpen;
    logic     ctxLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/trap_ctx_ctrl.sv
module trap_ctx_ctrl
  import trap_ctx_pkg::*;
#(
  parameter int PUSH_BYTES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        ctxLoadReq,
  input  logic        wakeIn,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        sleeping
);
  localparam int STEP_W = $clog2(PUSH_BYTES + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PUSH_BYTES - 1);
  localparam logic [STEP_W-1:0] TAIL_STEP = STEP_W'(PUSH_BYTES);

  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_PUSH, ST_VEC, ST_POP, ST_SLEEP} state_e;

  state_e state, nextState;
  logic [STEP_W-1:0] step, nextStep;
  capSel_e capQ, capNext;
  logic doneQ, finish;
  cmdOp_e op;

  assign op = cmdOp_e'(cmdOp);

  always_comb begin
    strobe = '0;
    strobe.addrSel = ADDR_SP;
    strobe.wrSel = BYTE_PCL;
    strobe.capSel = capQ;
    capNext = CAP_NONE;
    nextState = state;
    nextStep = step;
    finish = 1'b0;
    case (state)
      ST_BOOT, ST_VEC: begin
        strobe.vecTrap = (state == ST_VEC);
        if (step == '0) begin
          strobe.addrSel = ADDR_VEC_HI;
          capNext = CAP_PCH;
          nextStep = step + 1'b1;
        end else if (step == STEP_W'(1)) begin
          strobe.addrSel = ADDR_VEC_LO;
          capNext = CAP_PCL;
          nextStep = step + 1'b1;
        end else begin
          finish = 1'b1;
          nextState = ST_IDLE;
          nextStep = '0;
        end
      end
      ST_PUSH: begin
        strobe.memWe = 1'b1;
        strobe.spDec = 1'b1;
        strobe.wrSel = byteSel_e'(3'(step));
        if (step == LAST_STEP) begin
          strobe.maskFull = 1'b1;
          nextState = ST_VEC;
          nextStep = '0;
        end else begin
          nextStep = step + 1'b1;
        end
      end
      ST_POP: begin
        if (step != TAIL_STEP) begin
          strobe.addrSel = ADDR_SP_NEXT;
          strobe.spInc = 1'b1;
          nextStep = step + 1'b1;
          case (3'(step))
            3'd0: capNext = CAP_CC;
            3'd1: capNext = CAP_A;
            3'd2: capNext = CAP_X;
            3'd3: capNext = CAP_PCH;
            default: capNext = CAP_PCL;
          endcase
        end else begin
          finish = 1'b1;
          nextState = ST_IDLE;
          nextStep = '0;
        end
      end
      ST_SLEEP: begin
        if (wakeIn) nextState = ST_IDLE;
      end
      default: begin
        if (cmdValid) begin
          case (op)
            OP_TRAP: begin nextState = ST_PUSH; nextStep = '0; end
            OP_IRET: begin nextState = ST_POP; nextStep = '0; end
            OP_STACK_RST: strobe.spReset = 1'b1;
            OP_MASK_SET: strobe.maskFull = 1'b1;
            OP_MASK_CLR: strobe.maskOpen = 1'b1;
            OP_HALT, OP_WAIT: begin
              strobe.maskOpen = 1'b1;
              nextState = ST_SLEEP;
            end
            default: ;
          endcase
        end else if (ctxLoadReq) begin
          strobe.ctxLoad = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_BOOT;
      step <= '0;
      capQ <= CAP_NONE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      step <= nextStep;
      capQ <= capNext;
      doneQ <= finish;
    end
  end

  assign busy = (state != ST_IDLE);
  assign sleeping = (state == ST_SLEEP);
  assign done = doneQ;
endmodule

// File: rtl/trap_ctx_dpath.sv
module trap_ctx_dpath
  import trap_ctx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = 16'h01FF,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 16'hFFFC,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] accIn,
  input  logic [BYTE_W-1:0] xIn,
  input  logic [3:0]        flagsIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [BYTE_W-1:0] accOut,
  output logic [BYTE_W-1:0] xOut,
  output logic [BYTE_W-1:0] ccOut,
  output logic [ADDR_W-1:0] spOut
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam int HI = ADDR_W - 1;
  localparam int MID = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] pcQ, spQ, vecBase;
  logic [BYTE_W-1:0] accQ, xQ, ccPacked;
  logic hQ, nQ, zQ, cQ, i1Q, i0Q;

  assign ccPacked = {2'b11, i1Q, hQ, i0Q, nQ, zQ, cQ};
  assign vecBase = strobe.vecTrap ? TRAP_VEC : RESET_VEC;

  always_comb begin
    case (strobe.addrSel)
      ADDR_SP_NEXT: memAddr = spQ + ONE;
      ADDR_VEC_HI:  memAddr = vecBase;
      ADDR_VEC_LO:  memAddr = vecBase + ONE;
      default:      memAddr = spQ;
    endcase
    case (strobe.wrSel)
      BYTE_PCH: memWdata = pcQ[HI:MID];
      BYTE_X:   memWdata = xQ;
      BYTE_A:   memWdata = accQ;
      BYTE_CC:  memWdata = ccPacked;
      default:  memWdata = pcQ[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      accQ <= '0;
      xQ <= '0;
      {hQ, nQ, zQ, cQ} <= 4'b0000;
      {i1Q, i0Q} <= 2'b11;
      spQ <= STACK_TOP;
    end else begin
      if (strobe.ctxLoad) begin
        pcQ <= pcIn;
        accQ <= accIn;
        xQ <= xIn;
        {hQ, nQ, zQ, cQ} <= flagsIn;
      end
      if (strobe.spReset) spQ <= STACK_TOP;
      else if (strobe.spDec) spQ <= spQ - ONE;
      else if (strobe.spInc) spQ <= spQ + ONE;
      else if (strobe.ctxLoad) spQ <= spIn;
      if (strobe.maskFull) {i1Q, i0Q} <= 2'b11;
      else if (strobe.maskOpen) {i1Q, i0Q} <= 2'b10;
      case (strobe.capSel)
        CAP_PCH: pcQ[HI:MID] <= memRdata;
        CAP_PCL: pcQ[BYTE_W-1:0] <= memRdata;
        CAP_A:   accQ <= memRdata;
        CAP_X:   xQ <= memRdata;
        CAP_CC: begin
          cQ <= memRdata[0];
          zQ <= memRdata[1];
          nQ <= memRdata[2];
          i0Q <= memRdata[3];
          hQ <= memRdata[4];
          i1Q <= memRdata[5];
        end
        default: ;
      endcase
    end
  end

  assign memWe = strobe.memWe;
  assign pcOut = pcQ;
  assign accOut = accQ;
  assign xOut = xQ;
  assign ccOut = ccPacked;
  assign spOut = spQ;
endmodule

// File: rtl/trap_ctx_sequencer.sv
module trap_ctx_sequencer
  import trap_ctx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = 16'h01FF,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 16'hFFFC,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              ctxLoad,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [7:0]        accIn,
  input  logic [7:0]        xIn,
  input  logic [3:0]        flagsIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              wakeIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        accOut,
  output logic [7:0]        xOut,
  output logic [7:0]        ccOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              busy,
  output logic              done,
  output logic              sleeping
);
  localparam int PUSH_BYTES = 5;

  ctrlStrobe_t strobe;

  trap_ctx_ctrl #(.PUSH_BYTES(PUSH_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .ctxLoadReq(ctxLoad), .wakeIn(wakeIn), .strobe(strobe),
    .busy(busy), .done(done), .sleeping(sleeping)
  );

  trap_ctx_dpath #(
    .ADDR_W(ADDR_W), .STACK_TOP(STACK_TOP), .TRAP_VEC(TRAP_VEC), .RESET_VEC(RESET_VEC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn), .accIn(accIn),
    .xIn(xIn), .flagsIn(flagsIn), .spIn(spIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .pcOut(pcOut),
    .accOut(accOut), .xOut(xOut), .ccOut(ccOut), .spOut(spOut)
  );
endmodule

// File: rtl/trap_ctx_checks.sv
module trap_ctx_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              ctxLoad,
  input logic              wakeIn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] spOut,
  input logic [7:0]        ccOut,
  input logic              busy,
  input logic              done,
  input logic              sleeping
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R12
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) memWe |-> busy); // R11
  AST_WRITE_DEC_SP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - ADDR_W'(1)); // R3
  AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rstN) memWe |-> memAddr == spOut); // R2
  AST_SLEEP_IS_BUSY: assert property (@(posedge clk) disable iff (!rstN) sleeping |-> busy); // R10
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && !wakeIn |=> sleeping); // R10
  AST_SLEEP_SP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |=> $stable(spOut)); // R11
  AST_CC_TOP_ONES: assert property (@(posedge clk) disable iff (!rstN) ccOut[7:6] == 2'b11); // R4
  AST_IDLE_SP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !cmdValid && !ctxLoad |=> $stable(spOut)); // R11
endmodule

bind trap_ctx_sequencer trap_ctx_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .ctxLoad(ctxLoad), .wakeIn(wakeIn),
  .memWe(memWe), .memAddr(memAddr), .spOut(spOut), .ccOut(ccOut), .busy(busy),
  .done(done), .sleeping(sleeping)
);

// File: tb/sim_trap_ctx_sequencer.sv
module sim_trap_ctx_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd7;
  logic ctxLoad = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0] accIn = '0;
  logic [7:0] xIn = '0;
  logic [3:0] flagsIn = '0;
  logic [15:0] spIn = '0;
  logic wakeIn = 1'b0;
  logic [15:0] memAddr;
  logic [7:0] memWdata;
  logic memWe;
  logic [7:0] memRdata = '0;
  logic [15:0] pcOut, spOut;
  logic [7:0] accOut, xOut, ccOut;
  logic busy, done, sleeping;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [7:0] stackMem [0:511];
  logic [7:0] rvHi = 8'h12, rvLo = 8'h34, tvHi = 8'hA5, tvLo = 8'h5C;

  always #10 clk = ~clk;

  trap_ctx_sequencer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .ctxLoad(ctxLoad),
    .pcIn(pcIn), .accIn(accIn), .xIn(xIn), .flagsIn(flagsIn), .spIn(spIn),
    .wakeIn(wakeIn), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .pcOut(pcOut), .accOut(accOut), .xOut(xOut),
    .ccOut(ccOut), .spOut(spOut), .busy(busy), .done(done), .sleeping(sleeping)
  );

  function automatic logic [7:0] readByte(input logic [15:0] a);
    if (a == 16'hFFFC) return tvHi;
    if (a == 16'hFFFD) return tvLo;
    if (a == 16'hFFFE) return rvHi;
    if (a == 16'hFFFF) return rvLo;
    if (a < 16'd512) return stackMem[a[8:0]];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (memWe) begin
      wrCount <= wrCount + 1;
      if (memAddr < 16'd512) stackMem[memAddr[8:0]] <= memWdata;
    end
    memRdata <= readByte(memAddr);
  end

  function automatic logic [7:0] packCc(input logic i1, input logic i0, input logic [3:0] f);
    return {2'b11, i1, f[3], i0, f[2], f[1], f[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = 3'd7;
  endtask

  task automatic loadCtx(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] x,
                         input logic [3:0] f, input logic [15:0] sp);
    @(negedge clk);
    ctxLoad = 1'b1; pcIn = pc; accIn = a; xIn = x; flagsIn = f; spIn = sp;
    @(negedge clk);
    ctxLoad = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int w0;
    logic [15:0] pc0, sp0;
    logic [7:0] a0, x0, cc0;
    logic [3:0] f0;
    logic i1, i0;
    logic [7:0] b [0:4];
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) stackMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitDone(lat);
    // R1 boot
    chk(done == 1'b1, "R1 boot done", done, 1);
    chk(pcOut == 16'h1234, "R1 reset vector", pcOut, 16'h1234);
    chk(spOut == 16'h01FF, "R1 sp", spOut, 16'h01FF);
    chk(ccOut == 8'hE8, "R1 cc", ccOut, 8'hE8);
    chk(accOut == 0 && xOut == 0 && !busy, "R1 regs", {accOut, xOut}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 pulse width", done, 0);

    // R8 stack reset
    loadCtx(16'h0, 8'h0, 8'h0, 4'h0, 16'h0100);
    chk(spOut == 16'h0100, "R8 preload", spOut, 16'h0100);
    issue(3'd2);
    chk(spOut == 16'h01FF, "R8 stack reset", spOut, 16'h01FF);

    // R9 mask commands
    issue(3'd4);
    chk(ccOut[5] == 1'b1 && ccOut[3] == 1'b0, "R9 mask reset", ccOut, 8'hE0);
    issue(3'd3);
    chk(ccOut[5] == 1'b1 && ccOut[3] == 1'b1, "R9 mask set", ccOut, 8'hE8);

    // R11 no-op code
    issue(3'd7);
    chk(spOut == 16'h01FF && ccOut == 8'hE8, "R11 op7 no effect", {spOut, ccOut}, 24'h01FFE8);

    // trap then return, random
    for (int it = 0; it < 24; it++) begin
      pc0 = 16'($urandom); a0 = 8'($urandom); x0 = 8'($urandom); f0 = 4'($urandom);
      sp0 = 16'($urandom_range(511, 16));
      if (it == 0) sp0 = 16'h01FF;
      if (it == 1) sp0 = 16'h0004;
      i1 = 1'b1;
      i0 = 1'($urandom);
      if (i0) issue(3'd3); else issue(3'd4);
      loadCtx(pc0, a0, x0, f0, sp0);
      cc0 = packCc(i1, i0, f0);
      chk(ccOut == cc0, "R4 packing", ccOut, cc0);
      w0 = wrCount;
      issue(3'd0);
      waitDone(lat);
      chk(lat == 9, "R12 trap latency", lat, 9);
      chk(wrCount - w0 == 5, "R3 write count", wrCount - w0, 5);
      chk(spOut == sp0 - 16'd5, "R3 sp after trap", spOut, sp0 - 16'd5);
      chk(stackMem[sp0[8:0]] == pc0[7:0], "R2 pc low", stackMem[sp0[8:0]], pc0[7:0]);
      chk(stackMem[9'(sp0 - 1)] == pc0[15:8], "R2 pc high", stackMem[9'(sp0 - 1)], pc0[15:8]);
      chk(stackMem[9'(sp0 - 2)] == x0, "R2 x", stackMem[9'(sp0 - 2)], x0);
      chk(stackMem[9'(sp0 - 3)] == a0, "R2 a", stackMem[9'(sp0 - 3)], a0);
      chk(stackMem[9'(sp0 - 4)] == cc0, "R4 stacked cc", stackMem[9'(sp0 - 4)], cc0);
      chk(pcOut == {tvHi, tvLo}, "R5 trap vector", pcOut, {tvHi, tvLo});
      chk(ccOut == packCc(1'b1, 1'b1, f0), "R5 mask full", ccOut, packCc(1'b1, 1'b1, f0));
      chk(accOut == a0 && xOut == x0, "R5 a/x kept", {accOut, xOut}, {a0, x0});
      issue(3'd1);
      waitDone(lat);
      chk(lat == 7, "R12 iret latency", lat, 7);
      chk(spOut == sp0, "R6 sp restored", spOut, sp0);
      chk(pcOut == pc0 && accOut == a0 && xOut == x0, "R6 regs restored",
          {pcOut, accOut, xOut}, {pc0, a0, x0});
      chk(ccOut == cc0, "R7 cc restored", ccOut, cc0);
    end

    // return from random stack contents
    for (int it = 0; it < 12; it++) begin
      sp0 = 16'($urandom_range(506, 0));
      for (int k = 0; k < 5; k++) begin
        b[k] = 8'($urandom);
        stackMem[9'(sp0 + 16'(k + 1))] = b[k];
      end
      loadCtx(16'h0, 8'h0, 8'h0, 4'h0, sp0);
      issue(3'd1);
      waitDone(lat);
      chk(ccOut == {2'b11, b[0][5:0]}, "R7 cc from stack", ccOut, {2'b11, b[0][5:0]});
      chk(accOut == b[1] && xOut == b[2], "R6 a/x order", {accOut, xOut}, {b[1], b[2]});
      chk(pcOut == {b[3], b[4]}, "R6 pc big-endian", pcOut, {b[3], b[4]});
      chk(spOut == sp0 + 16'd5, "R6 sp plus five", spOut, sp0 + 16'd5);
    end

    // R11 requests ignored while busy
    loadCtx(16'hBEEF, 8'h11, 8'h22, 4'h5, 16'h0180);
    issue(3'd0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd1; ctxLoad = 1'b1; accIn = 8'h99; spIn = 16'h0010;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd7; ctxLoad = 1'b0;
    waitDone(lat);
    chk(lat == 7, "R11 trap not disturbed", lat, 7);
    chk(spOut == 16'h017B && accOut == 8'h11, "R11 busy ignore", {spOut, accOut}, 24'h017B11);
    repeat (3) @(negedge clk);
    chk(spOut == 16'h017B && !busy, "R11 no queued iret", spOut, 16'h017B);

    // R11 ctxLoad with command same cycle
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd3; ctxLoad = 1'b1; accIn = 8'h77;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd7; ctxLoad = 1'b0;
    chk(accOut == 8'h11, "R11 load with command", accOut, 8'h11);

    // R10 halt and wait
    for (int m = 0; m < 2; m++) begin
      issue(3'd3);
      sp0 = spOut;
      issue(m == 0 ? 3'd5 : 3'd6);
      chk(sleeping && busy, "R10 asleep", {sleeping, busy}, 2'b11);
      chk(ccOut[5] == 1'b1 && ccOut[3] == 1'b0, "R10 mask open", ccOut[5:3], 3'b100);
      w0 = wrCount;
      issue(3'd0);
      repeat (6) @(negedge clk);
      chk(sleeping && spOut == sp0 && wrCount == w0, "R10 trap ignored asleep", spOut, sp0);
      wakeIn = 1'b1;
      @(negedge clk);
      wakeIn = 1'b0;
      chk(!sleeping && !busy, "R10 wake", {sleeping, busy}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule